// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

This block gives a group of up to 32 bus masters a way to signal each other. It holds a set of doorbell channels, and each channel belongs to one receiving master. Any master rings a channel by writing to that channel's trigger register over a shared register bus. Each write on the bus carries the ID of the master that issued it. The unit records which master rang the channel as a bit position. Every ring is logged in a raw register. A per-channel enable mask decides which rings are also logged in a pending register. The owner of each channel gets a level interrupt that stays high while any pending bit is set.

The owner services the interrupt in two steps. It reads the pending register to learn who rang. It then writes the same value back, which clears exactly those bits. A master can find out whether it may ring a target channel by reading that channel's enable register and testing the bit at its own ID. A ring takes effect one cycle after its trigger write. If a clear of the same bit lands in that cycle, the ring wins.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every enable, raw and pending register reads zero and every interrupt output is low.
- R2: Each channel d has a register window at byte address d*0x100. Within the window, bits 3:2 of the address select the register: 0 for trigger, 1 for enable, 2 for raw, 3 for pending. The trigger register reads as zero. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R3: A write to a trigger register with bit 0 set rings that channel as master `bus_mid`. A trigger write with bit 0 clear has no effect.
- R4: A ring from master m sets bit m of the raw register, whatever the enable mask holds.
- R5: A ring from master m sets bit m of the pending register only when bit m of the enable register is 1.
- R6: The enable register is a plain 32-bit read/write register.
- R7: A write to the pending register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: A write to the raw register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: A ring lands in the register one cycle after its trigger write. When a clear of the same bit arrives in that same cycle, the bit stays set.
- R10: The interrupt output of each channel is high exactly while its pending register is nonzero. It follows pending in the same cycle that pending changes.
- R11: A write affects only the channel that its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | IDX_W+8 (11) | Byte address |
| bus_wdata | input | N_MST (32) | Write data |
| bus_mid | input | $clog2(N_MST) (5) | ID of the master issuing the write |
| bus_rdata | output | N_MST (32) | Registered read data |
| db_irq | output | N_DB (8) | Level interrupt, one per channel |

## Verification
Two kinds of fault show up in different places.

A wrong pending bit shows up at `db_irq` right away. The interrupt changes on the second clock edge after the trigger write, so a pending bit that was set wrongly, or a clear that was lost, appears there with no read at all.

Faults in the raw or enable registers, or in the bit position taken from the master ID, stay hidden until a read. They show on `bus_rdata` one cycle after the read strobe. The tests therefore read back every affected register after each scenario. They also read an untouched neighbouring channel to catch decode faults.

The set-over-clear rule has its own test. It issues a clear in the exact cycle in which a pending ring lands, so a design where the clear wins would lose that bit.

// File: rtl/db_pkg.sv
package db_pkg;
  // Register select taken from address bits 3:2 inside a channel window
  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_EN   = 2'd1,
    REG_RAW  = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  // Channel windows are 256 bytes apart
  localparam int WIN_LSB = 8;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int N_DB  = 8,
  parameter int IDX_W = 3
) (
  input  logic                     wr,
  input  logic                     rd,
  input  logic [IDX_W+WIN_LSB-1:0] addr,
  output logic [N_DB-1:0]          wr_hit,
  output logic                     rd_hit,
  output logic [IDX_W-1:0]         idx,
  output reg_sel_e                 sel
);
  logic [N_DB-1:0] idx_hit;
  logic            unused_addr_bits;

  assign idx = addr[IDX_W+WIN_LSB-1:WIN_LSB];
  assign sel = reg_sel_e'(addr[3:2]);
  assign unused_addr_bits = ^{addr[WIN_LSB-1:4], addr[1:0]};

  // One compare per channel; an index beyond N_DB matches none of them
  for (genvar d = 0; d < N_DB; d++) begin : g_hit
    assign idx_hit[d] = (idx == IDX_W'(d));
    assign wr_hit[d]  = wr && idx_hit[d];
  end

  assign rd_hit = rd && (|idx_hit);
endmodule

// File: rtl/db_channel.sv
module db_channel
  import db_pkg::*;
#(
  parameter int N_MST = 32,
  parameter int MID_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  reg_sel_e         sel,
  input  logic [N_MST-1:0] wdata,
  input  logic [MID_W-1:0] mid,
  output logic [N_MST-1:0] en_q,
  output logic [N_MST-1:0] raw_q,
  output logic [N_MST-1:0] pend_q,
  output logic             irq_q
);
  logic             ring_v_q;
  logic [MID_W-1:0] ring_id_q;
  logic [N_MST-1:0] ring_vec;
  logic [N_MST-1:0] clr_raw;
  logic [N_MST-1:0] clr_pend;
  logic [N_MST-1:0] raw_nxt;
  logic [N_MST-1:0] pend_nxt;

  // Stage the trigger so the set logic sees a registered master ID
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_v_q  <= 1'b0;
      ring_id_q <= '0;
    end else begin
      ring_v_q  <= wr_hit && (sel == REG_TRIG) && wdata[0];
      ring_id_q <= mid;
    end
  end

  always_comb begin
    ring_vec = '0;
    if (ring_v_q) ring_vec[ring_id_q] = 1'b1;
  end

  assign clr_raw  = (wr_hit && sel == REG_RAW)  ? wdata : '0;
  assign clr_pend = (wr_hit && sel == REG_PEND) ? wdata : '0;

  // OR-ing the set term after the clear makes the ring win a same-cycle clear
  assign raw_nxt  = (raw_q  & ~clr_raw)  | ring_vec;
  assign pend_nxt = (pend_q & ~clr_pend) | (ring_vec & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_hit && sel == REG_EN) en_q <= wdata;
      raw_q  <= raw_nxt;
      pend_q <= pend_nxt;
      irq_q  <= |pend_nxt;
    end
  end

  AST_RING_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    ring_v_q |=> raw_q[$past(ring_id_q)]); // R4

  AST_PEND_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(ring_vec) & $past(en_q))) == '0)); // R5

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == REG_PEND && !ring_v_q) |=> ((pend_q & $past(wdata)) == '0)); // R7

  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q != '0)); // R10
endmodule

// File: rtl/db_rdmux.sv
module db_rdmux
  import db_pkg::*;
#(
  parameter int N_DB  = 8,
  parameter int N_MST = 32,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_hit,
  input  logic [IDX_W-1:0]           idx,
  input  reg_sel_e                   sel,
  input  logic [N_DB-1:0][N_MST-1:0] en_arr,
  input  logic [N_DB-1:0][N_MST-1:0] raw_arr,
  input  logic [N_DB-1:0][N_MST-1:0] pend_arr,
  output logic [N_MST-1:0]           rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      case (sel)
        REG_EN:   rdata <= en_arr[idx];
        REG_RAW:  rdata <= raw_arr[idx];
        REG_PEND: rdata <= pend_arr[idx];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int N_DB  = 8,
  parameter int N_MST = 32,
  localparam int IDX_W  = (N_DB > 1) ? $clog2(N_DB) : 1,
  localparam int MID_W  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int ADDR_W = IDX_W + WIN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_MST-1:0]  bus_wdata,
  input  logic [MID_W-1:0]  bus_mid,
  output logic [N_MST-1:0]  bus_rdata,
  output logic [N_DB-1:0]   db_irq
);
  logic [N_DB-1:0]            wr_hit;
  logic                       rd_hit;
  logic [IDX_W-1:0]           idx;
  reg_sel_e                   sel;
  logic [N_DB-1:0][N_MST-1:0] en_arr;
  logic [N_DB-1:0][N_MST-1:0] raw_arr;
  logic [N_DB-1:0][N_MST-1:0] pend_arr;

  db_decode #(.N_DB(N_DB), .IDX_W(IDX_W)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .idx(idx), .sel(sel)
  );

  for (genvar d = 0; d < N_DB; d++) begin : g_ch
    db_channel #(.N_MST(N_MST), .MID_W(MID_W)) u_ch (
      .clk(clk), .rst(rst), .wr_hit(wr_hit[d]), .sel(sel),
      .wdata(bus_wdata), .mid(bus_mid),
      .en_q(en_arr[d]), .raw_q(raw_arr[d]), .pend_q(pend_arr[d]),
      .irq_q(db_irq[d])
    );
  end

  db_rdmux #(.N_DB(N_DB), .N_MST(N_MST), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .idx(idx), .sel(sel),
    .en_arr(en_arr), .raw_arr(raw_arr), .pend_arr(pend_arr),
    .rdata(bus_rdata)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit)); // R11
endmodule

// File: tb/tb_doorbell_unit.sv
module tb_doorbell_unit;
  localparam int N_DB = 8;
  localparam int N_MST = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [4:0]  bus_mid = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  db_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  doorbell_unit #(.N_DB(N_DB), .N_MST(N_MST)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
    .bus_rdata(bus_rdata), .db_irq(db_irq)
  );

  function automatic logic [10:0] ad(int db, int rg);
    return 11'(db * 256 + rg * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d, logic [4:0] m);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_mid = m;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [10:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ring(int db, logic [4:0] m);
    wr(ad(db, 0), 32'h1, m);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 1; r < 4; r++) begin
      rd(ad(0, r), v); check("R1 db0", v, 0);
      rd(ad(7, r), v); check("R1 db7", v, 0);
    end
    check("R1 irq", 32'(db_irq), 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(ad(2, 1), 32'hA5A5_F00F, 5'd0);
    rd(ad(2, 1), v); check("R6 enable readback", v, 32'hA5A5_F00F);
    rd(ad(3, 1), v); check("R11 neighbour enable", v, 0);
  endtask

  task automatic t_ring_enabled();
    logic [31:0] v;
    wr(ad(1, 1), 32'h10, 5'd0);
    ring(1, 5'd4);
    check("R10 irq after enabled ring", 32'(db_irq), 32'h02);
    rd(ad(1, 2), v); check("R4 raw", v, 32'h10);
    rd(ad(1, 3), v); check("R5 pend enabled", v, 32'h10);
    rd(ad(1, 0), v); check("R2 trigger reads zero", v, 0);
  endtask

  task automatic t_ring_disabled();
    logic [31:0] v;
    ring(1, 5'd9);
    rd(ad(1, 2), v); check("R4 raw ignores mask", v, 32'h210);
    rd(ad(1, 3), v); check("R5 pend masked", v, 32'h10);
    wr(ad(1, 0), 32'h2, 5'd12);
    @(negedge clk);
    rd(ad(1, 2), v); check("R3 bit0 clear no ring", v, 32'h210);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(ad(1, 3), 32'h10, 5'd0);
    check("R10 irq after clear", 32'(db_irq), 0);
    rd(ad(1, 3), v); check("R7 pend cleared", v, 0);
    wr(ad(1, 2), 32'h200, 5'd0);
    rd(ad(1, 2), v); check("R8 raw partial clear", v, 32'h10);
    wr(ad(1, 1), 32'h8000_0001, 5'd0);
    ring(1, 5'd0);
    ring(1, 5'd31);
    rd(ad(1, 3), v); check("R5 pend edge bits", v, 32'h8000_0001);
    wr(ad(1, 3), 32'h1, 5'd0);
    rd(ad(1, 3), v); check("R7 zero bits kept", v, 32'h8000_0000);
    check("R10 irq still high", 32'(db_irq), 32'h02);
    wr(ad(1, 3), 32'h8000_0000, 5'd0);
    check("R10 irq low", 32'(db_irq), 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(ad(6, 1), 32'h20, 5'd0);
    ring(6, 5'd5);
    wr(ad(6, 0), 32'h1, 5'd5);
    wr(ad(6, 3), 32'h20, 5'd0);
    rd(ad(6, 3), v); check("R9 set beats clear", v, 32'h20);
    check("R9 irq kept", 32'(db_irq), 32'h40);
    wr(ad(6, 3), 32'h20, 5'd0);
    rd(ad(6, 3), v); check("R9 later clear", v, 0);
  endtask

  task automatic t_isolation();
    logic [31:0] v;
    wr(ad(0, 1), 32'hFFFF_FFFF, 5'd0);
    ring(0, 5'd3);
    check("R11 irq only db0", 32'(db_irq), 32'h01);
    rd(ad(0, 3), v); check("R11 db0 pend", v, 32'h8);
    rd(ad(7, 3), v); check("R11 db7 pend", v, 0);
    rd(ad(2, 2), v); check("R11 db2 raw", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_ring_enabled();
    t_ring_disabled();
    t_clear();
    t_set_wins();
    t_isolation();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule